// File: doc/BRIEF.md
# PC Card Attribute Configuration Registers

This block serves the attribute-memory space of a 16-bit PC Card storage function. A host issues byte reads and byte writes on an attribute address bus. Below a fixed configuration base address, the read data comes from a card-information ROM that is given to the block as a parameter. At the base address and above it, the block decodes four configuration registers: an option register, a card status register, a pin replacement register and a socket/copy register.

The block also holds the two control bits that a neighbouring task-file path writes into the device-control register. It combines them with the interrupt level of an attached disk controller and with the option register to drive one host interrupt line. When a write sets the soft-reset bit of the option register, the block sends a one-cycle reset pulse to the controller. Reads are combinational from registered state. Writes take effect on the rising clock edge.

Top module: `pccard_cfg_regs`

## Requirements
- R1: When the attribute address is below the base (0x200), the read data is byte N of the ROM image for an address N smaller than ROM_LEN, and 0x00 for any other address below the base. Writes below the base change no register.
- R2: A write to offset 0 (the option register) stores the data ANDed with 0xCF. A read of offset 0 returns the stored value. Bits 5:0 of the stored value drive `opt_mode`, and bit 6 drives `opt_level_irq`.
- R3: A write to offset 0 with data bit 7 set makes `srst_pulse` high for exactly the one cycle after that write edge, unless the next cycle holds another such write.
- R4: A write to offset 2 (the status register) sets the stored value to (old AND 0x82) OR (data AND 0x74). Status bit 1 follows `dsk_irq`, sampled on every clock edge.
- R5: When a status write changes the stored power-down bit (bit 2), the ready flag (pin replacement bit 5) is set. Once set, the ready flag stays set until reset.
- R6: A read of offset 2 returns the status with bit 1 forced to 0 while the held interrupt-disable bit (bit 1 of the device-control byte) is set.
- R7: A read of offset 4 returns the ready flag in bit 5, ORed with 0x0C. A write to offset 4 never clears the ready flag.
- R8: Offset 6 (the socket/copy register) and every other offset at or above the base that does not decode to a register read as 0x00. Writes to these addresses have no effect.
- R9: `host_irq` is high exactly when all of these hold: status bit 1 is 0, the held device-control bits 1 (interrupt disable) and 2 (soft reset) are both 0, and option bit 7 is 0.
- R10: Reset sets the option register to 0 (memory-mapped mode). It also clears the status register, the ready flag and both device-control bits.
- R11: A `dc_we` write loads bits 1 and 2 of `dc_wdata` into the held device-control bits on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attr_addr | input | AW | Attribute-space byte address |
| attr_we | input | 1 | Byte write strobe for attribute space |
| attr_wdata | input | 8 | Write data |
| attr_rdata | output | 8 | Combinational read data for attr_addr |
| dc_we | input | 1 | Device-control byte write from the task-file path |
| dc_wdata | input | 8 | Device-control byte |
| dsk_irq | input | 1 | Interrupt level from the disk controller |
| host_irq | output | 1 | Host interrupt request |
| srst_pulse | output | 1 | One-cycle soft-reset pulse to the controller |
| opt_mode | output | 6 | Addressing-mode field of the option register |
| opt_level_irq | output | 1 | Level-interrupt select of the option register |

## Verification
The hardest case to reach from the ports is a status read at the moment the controller interrupt is high and the interrupt-disable bit is set. The same holds for the ready flag, which is set only when a status write flips the power-down bit against the value already stored. To reach these, the random stimulus puts most accesses on the four register offsets. It toggles `dsk_irq` and the device-control bits independently of the attribute writes, so a stored power-down bit meets a write carrying both the same bit and the opposite bit. Directed steps first cover the reset values, the option mask and the pulse, ROM bytes at and past the ROM length, and unmapped offsets.

// File: rtl/pccfg_pkg.sv
package pccfg_pkg;

   // register offsets from the configuration base; a neighbour decodes these
   localparam int OFS_OPT  = 0;
   localparam int OFS_STAT = 2;
   localparam int OFS_PIN  = 4;
   localparam int OFS_SOCK = 6;

   // option register
   localparam logic [7:0] OPT_WMASK   = 8'hCF;
   localparam int         OPT_SRST_B  = 7;
   localparam int         OPT_LEVEL_B = 6;
   localparam int         MODE_W      = 6;

   // status register
   localparam logic [7:0] STAT_KEEP = 8'h82;
   localparam logic [7:0] STAT_LOAD = 8'h74;
   localparam int         STAT_INT_B = 1;
   localparam int         STAT_PDN_B = 2;

   // pin replacement register
   localparam int         PIN_RDY_B  = 5;
   localparam logic [7:0] PIN_CONST  = 8'h0C;

   // device-control bits held here
   localparam int DC_IDIS_B = 1;
   localparam int DC_SRST_B = 2;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ROM,
      SEL_OPT,
      SEL_STAT,
      SEL_PIN,
      SEL_SOCK
   } sel_e;

endpackage

// File: rtl/pccfg_decode.sv
module pccfg_decode
   import pccfg_pkg::*;
#(
   parameter int AW      = 12,
   parameter int BASE    = 'h200,
   parameter int ROM_LEN = 16,
   localparam int IDXW   = (ROM_LEN > 1) ? $clog2(ROM_LEN) : 1
) (
   input  logic [AW-1:0]   addr,
   output sel_e            sel,
   output logic [IDXW-1:0] rom_idx
);

   localparam logic [AW-1:0] BASE_A = AW'(BASE);

   logic [AW-1:0] ofs;

   assign ofs     = addr - BASE_A;
   assign rom_idx = IDXW'(addr);

   always_comb begin
      sel = SEL_NONE;
      if (addr < BASE_A) begin
         if (32'(addr) < ROM_LEN) sel = SEL_ROM;
      end else begin
         case (32'(ofs))
            OFS_OPT:  sel = SEL_OPT;
            OFS_STAT: sel = SEL_STAT;
            OFS_PIN:  sel = SEL_PIN;
            OFS_SOCK: sel = SEL_SOCK;
            default:  sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/pccfg_rom.sv
module pccfg_rom #(
   parameter int                   ROM_LEN   = 16,
   parameter logic [8*ROM_LEN-1:0] ROM_IMAGE = '0,
   localparam int                  IDXW      = (ROM_LEN > 1) ? $clog2(ROM_LEN) : 1
) (
   input  logic [IDXW-1:0] idx,
   output logic [7:0]      data
);

   generate
      if (ROM_LEN == 0) begin : g_empty
         assign data = 8'h00;
      end else begin : g_mux
         always_comb begin
            data = 8'h00;
            for (int i = 0; i < ROM_LEN; i++) begin
               if (32'(idx) == i) data = ROM_IMAGE[8*i +: 8];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pccfg_regs.sv
module pccfg_regs
   import pccfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_opt,
   input  logic       wr_stat,
   input  logic [7:0] wdata,
   input  logic       dsk_irq,
   input  logic       dc_we,
   input  logic [7:0] dc_wdata,
   output logic [7:0] opt_q,
   output logic [7:0] stat_q,
   output logic       rdy_q,
   output logic       dc_idis_q,
   output logic       dc_srst_q,
   output logic       pulse_q
);

   logic [7:0] stat_d;
   logic       pdn_flip;

   assign pdn_flip = wr_stat && (stat_q[STAT_PDN_B] != wdata[STAT_PDN_B]);

   always_comb begin
      stat_d = stat_q;
      if (wr_stat) stat_d = (stat_q & STAT_KEEP) | (wdata & STAT_LOAD);
      stat_d[STAT_INT_B] = dsk_irq;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opt_q     <= 8'h00;
         stat_q    <= 8'h00;
         rdy_q     <= 1'b0;
         dc_idis_q <= 1'b0;
         dc_srst_q <= 1'b0;
         pulse_q   <= 1'b0;
      end else begin
         if (wr_opt) opt_q <= wdata & OPT_WMASK;
         stat_q  <= stat_d;
         if (pdn_flip) rdy_q <= 1'b1;
         if (dc_we) begin
            dc_idis_q <= dc_wdata[DC_IDIS_B];
            dc_srst_q <= dc_wdata[DC_SRST_B];
         end
         pulse_q <= wr_opt && wdata[OPT_SRST_B];
      end
   end

endmodule

// File: rtl/pccfg_irq.sv
module pccfg_irq
   import pccfg_pkg::*;
(
   input  logic [7:0] stat_q,
   input  logic [7:0] opt_q,
   input  logic       dc_idis_q,
   input  logic       dc_srst_q,
   output logic       host_irq
);

   // status interrupt bit is active low toward the host
   assign host_irq = !stat_q[STAT_INT_B] && !dc_idis_q && !dc_srst_q
                     && !opt_q[OPT_SRST_B];

endmodule

// File: rtl/pccard_cfg_regs.sv
module pccard_cfg_regs
   import pccfg_pkg::*;
#(
   parameter int                   AW        = 12,
   parameter int                   BASE      = 'h200,
   parameter int                   ROM_LEN   = 16,
   parameter logic [8*ROM_LEN-1:0] ROM_IMAGE = {
      8'h0F, 8'h0E, 8'h0D, 8'h0C, 8'h0B, 8'h0A, 8'h09, 8'h08,
      8'h07, 8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01, 8'h00}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [AW-1:0]         attr_addr,
   input  logic                  attr_we,
   input  logic [7:0]            attr_wdata,
   output logic [7:0]            attr_rdata,
   input  logic                  dc_we,
   input  logic [7:0]            dc_wdata,
   input  logic                  dsk_irq,
   output logic                  host_irq,
   output logic                  srst_pulse,
   output logic [MODE_W-1:0]     opt_mode,
   output logic                  opt_level_irq
);

   localparam int IDXW = (ROM_LEN > 1) ? $clog2(ROM_LEN) : 1;

   generate
      if (BASE + OFS_SOCK >= (1 << AW)) begin : g_chk_base
         $error("configuration registers do not fit the address width");
      end
      if (ROM_LEN > BASE) begin : g_chk_rom
         $error("ROM image overlaps the configuration registers");
      end
   endgenerate

   sel_e            sel;
   logic [IDXW-1:0] rom_idx;
   logic [7:0]      rom_data;
   logic [7:0]      opt_q;
   logic [7:0]      stat_q;
   logic            rdy_q;
   logic            dc_idis;
   logic            dc_srst;

   pccfg_decode #(.AW(AW), .BASE(BASE), .ROM_LEN(ROM_LEN)) u_dec (
      .addr    (attr_addr),
      .sel     (sel),
      .rom_idx (rom_idx)
   );

   pccfg_rom #(.ROM_LEN(ROM_LEN), .ROM_IMAGE(ROM_IMAGE)) u_rom (
      .idx  (rom_idx),
      .data (rom_data)
   );

   pccfg_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_opt    (attr_we && (sel == SEL_OPT)),
      .wr_stat   (attr_we && (sel == SEL_STAT)),
      .wdata     (attr_wdata),
      .dsk_irq   (dsk_irq),
      .dc_we     (dc_we),
      .dc_wdata  (dc_wdata),
      .opt_q     (opt_q),
      .stat_q    (stat_q),
      .rdy_q     (rdy_q),
      .dc_idis_q (dc_idis),
      .dc_srst_q (dc_srst),
      .pulse_q   (srst_pulse)
   );

   pccfg_irq u_irq (
      .stat_q    (stat_q),
      .opt_q     (opt_q),
      .dc_idis_q (dc_idis),
      .dc_srst_q (dc_srst),
      .host_irq  (host_irq)
   );

   always_comb begin
      case (sel)
         SEL_ROM:  attr_rdata = rom_data;
         SEL_OPT:  attr_rdata = opt_q;
         SEL_STAT: begin
            attr_rdata = stat_q;
            if (dc_idis) attr_rdata[STAT_INT_B] = 1'b0;
         end
         SEL_PIN:  attr_rdata = PIN_CONST | (8'(rdy_q) << PIN_RDY_B);
         default:  attr_rdata = 8'h00;
      endcase
   end

   assign opt_mode      = opt_q[MODE_W-1:0];
   assign opt_level_irq = opt_q[OPT_LEVEL_B];

endmodule

// File: rtl/pccfg_checker.sv
module pccfg_checker #(
   parameter int AW      = 12,
   parameter int BASE    = 'h200,
   parameter int ROM_LEN = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] attr_addr,
   input logic          attr_we,
   input logic [7:0]    attr_wdata,
   input logic [7:0]    attr_rdata,
   input logic          host_irq,
   input logic          srst_pulse,
   input logic          dc_idis
);

   logic srst_wr;
   assign srst_wr = attr_we && (attr_addr == AW'(BASE)) && attr_wdata[7];

   AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      srst_wr |=> srst_pulse); // R3
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (srst_pulse && !srst_wr) |=> !srst_pulse); // R3
   AST_IRQ_OFF_IN_SRST: assert property (@(posedge clk) disable iff (!rst_n)
      srst_pulse |-> !host_irq); // R9
   AST_STAT_INT_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_idis && attr_addr == AW'(BASE + 2)) |-> !attr_rdata[1]); // R6
   AST_PIN_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (attr_addr == AW'(BASE + 4)) |-> ((attr_rdata & 8'hDF) == 8'h0C)); // R7
   AST_SOCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (attr_addr == AW'(BASE + 6)) |-> (attr_rdata == 8'h00)); // R8
   AST_ROM_PAST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (attr_addr < AW'(BASE) && 32'(attr_addr) >= ROM_LEN) |-> (attr_rdata == 8'h00)); // R1

endmodule

bind pccard_cfg_regs pccfg_checker #(.AW(AW), .BASE(BASE), .ROM_LEN(ROM_LEN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .attr_addr  (attr_addr),
   .attr_we    (attr_we),
   .attr_wdata (attr_wdata),
   .attr_rdata (attr_rdata),
   .host_irq   (host_irq),
   .srst_pulse (srst_pulse),
   .dc_idis    (dc_idis)
);

// File: tb/pccard_cfg_regs_tb.sv
`timescale 1ns/1ps
module pccard_cfg_regs_tb;

   localparam int AW   = 12;
   localparam int BASE = 'h200;
   localparam int RL   = 24;

   function automatic logic [8*RL-1:0] mk_rom();
      logic [8*RL-1:0] v;
      for (int i = 0; i < RL; i++) v[8*i +: 8] = 8'((i * 29 + 3) & 255);
      return v;
   endfunction

   localparam logic [8*RL-1:0] IMG = mk_rom();

   logic          clk = 0;
   logic          rst_n = 0;
   logic [AW-1:0] attr_addr = '0;
   logic          attr_we = 0;
   logic [7:0]    attr_wdata = '0;
   logic [7:0]    attr_rdata;
   logic          dc_we = 0;
   logic [7:0]    dc_wdata = '0;
   logic          dsk_irq = 0;
   logic          host_irq;
   logic          srst_pulse;
   logic [5:0]    opt_mode;
   logic          opt_level_irq;

   always #10 clk = ~clk;

   pccard_cfg_regs #(.AW(AW), .BASE(BASE), .ROM_LEN(RL), .ROM_IMAGE(IMG)) u_dut (
      .clk(clk), .rst_n(rst_n), .attr_addr(attr_addr), .attr_we(attr_we),
      .attr_wdata(attr_wdata), .attr_rdata(attr_rdata), .dc_we(dc_we),
      .dc_wdata(dc_wdata), .dsk_irq(dsk_irq), .host_irq(host_irq),
      .srst_pulse(srst_pulse), .opt_mode(opt_mode), .opt_level_irq(opt_level_irq)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   logic [7:0] m_opt, m_stat;
   logic       m_rdy, m_idis, m_srst, m_pulse;

   function automatic logic [7:0] ref_read(input logic [AW-1:0] a);
      if (a < AW'(BASE)) return (32'(a) < RL) ? IMG[8*a +: 8] : 8'h00;
      case (32'(a) - BASE)
         0: return m_opt;
         2: return m_idis ? (m_stat & 8'hFD) : m_stat;
         4: return {2'b00, m_rdy, 5'b01100};
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic ref_irq();
      return !m_stat[1] && !m_idis && !m_srst && !m_opt[7];
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic rd(input string req, input logic [AW-1:0] a);
      attr_addr = a;
      #1;
      chk(req, attr_rdata, ref_read(a));
   endtask

   task automatic check_all();
      rd("R2 option", AW'(BASE));
      rd("R4 R6 status", AW'(BASE + 2));
      rd("R5 R7 pin", AW'(BASE + 4));
      rd("R8 socket", AW'(BASE + 6));
      chk("R9 host_irq", 8'(host_irq), 8'(ref_irq()));
      chk("R3 pulse", 8'(srst_pulse), 8'(m_pulse));
      chk("R2 mode", 8'(opt_mode), 8'(m_opt[5:0]));
      chk("R2 level", 8'(opt_level_irq), 8'(m_opt[6]));
   endtask

   // one clock: drive at negedge, update model after edge, check at next negedge
   task automatic step(input logic we, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic irq, input logic dwe, input logic [7:0] dd);
      attr_we = we; attr_addr = a; attr_wdata = d;
      dsk_irq = irq; dc_we = dwe; dc_wdata = dd;
      @(posedge clk);
      #1;
      m_pulse = we && (a == AW'(BASE)) && d[7];
      if (we && a == AW'(BASE)) m_opt = d & 8'hCF;
      if (we && a == AW'(BASE + 2)) begin
         if (m_stat[2] != d[2]) m_rdy = 1'b1;
         m_stat = (m_stat & 8'h82) | (d & 8'h74);
      end
      m_stat[1] = irq;
      if (dwe) begin m_idis = dd[1]; m_srst = dd[2]; end
      @(negedge clk);
      attr_we = 0; dc_we = 0;
      check_all();
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      m_opt = 0; m_stat = 0; m_rdy = 0; m_idis = 0; m_srst = 0; m_pulse = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      check_all();
      chk("R10 host_irq after reset", 8'(host_irq), 8'h01);

      // R1 ROM bytes, end of ROM, gap up to base
      rd("R1 rom first", AW'(0));
      rd("R1 rom last", AW'(RL - 1));
      rd("R1 past rom", AW'(RL));
      rd("R1 below base", AW'(BASE - 1));
      chk("R1 rom byte5 value", attr_rdata, 8'h00);
      attr_addr = AW'(5); #1;
      chk("R1 rom byte5", attr_rdata, 8'((5 * 29 + 3) & 255));

      // R1 write below base has no effect
      step(1, AW'(3), 8'hFF, 0, 0, 0);
      rd("R1 rom after write", AW'(3));

      // R2 option mask, R3 pulse, R9 gating
      step(1, AW'(BASE), 8'hFF, 0, 0, 0);
      chk("R2 option masked", ref_read(AW'(BASE)), 8'hCF);
      chk("R9 irq off with option bit7", 8'(host_irq), 8'h00);
      step(0, AW'(BASE), 8'h00, 0, 0, 0);
      chk("R3 pulse ended", 8'(srst_pulse), 8'h00);
      step(1, AW'(BASE), 8'h41, 0, 0, 0);

      // R4 R5 status load and ready flag
      step(1, AW'(BASE + 2), 8'hFF, 1, 0, 0);
      chk("R5 ready set", ref_read(AW'(BASE + 4)), 8'h2C);
      // R7 pin write cannot clear ready; R8 socket/unmapped writes ignored
      step(1, AW'(BASE + 4), 8'h00, 1, 0, 0);
      step(1, AW'(BASE + 6), 8'hFF, 1, 0, 0);
      step(1, AW'(BASE + 1), 8'hFF, 1, 0, 0);
      rd("R8 unmapped odd", AW'(BASE + 1));
      rd("R8 unmapped high", AW'(BASE + 8));
      // R6 hidden interrupt, R11 device control
      step(0, AW'(BASE), 8'h00, 1, 1, 8'h02);
      step(0, AW'(BASE), 8'h00, 0, 1, 8'h04);
      step(0, AW'(BASE), 8'h00, 0, 1, 8'h00);

      // reset again to check R10 after activity
      rst_n = 0;
      @(posedge clk); #1;
      m_opt = 0; m_stat = 0; m_rdy = 0; m_idis = 0; m_srst = 0; m_pulse = 0;
      @(negedge clk);
      rst_n = 1;
      check_all();

      // random phase
      for (int n = 0; n < 600; n++) begin
         logic [AW-1:0] a;
         logic [7:0]    d;
         int            k;
         k = int'($urandom_range(0, 9));
         case (k)
            0, 1: a = AW'(BASE);
            2, 3, 4: a = AW'(BASE + 2);
            5: a = AW'(BASE + 4);
            6: a = AW'(BASE + 6);
            7: a = AW'(BASE + $urandom_range(7, 40));
            default: a = AW'($urandom_range(0, BASE - 1));
         endcase
         d = 8'($urandom);
         if (a == AW'(BASE) && $urandom_range(0, 3) != 0) d[7] = 1'b0;
         step($urandom_range(0, 3) != 0, a, d, 1'($urandom),
              $urandom_range(0, 3) == 0, 8'($urandom));
         rd("R1 random low read", AW'($urandom_range(0, RL + 8)));
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule